// File: doc/BRIEF.md
# Protected Calendar Register Front End

This block is the bus-facing register layer that sits in front of a real-time calendar counter. Software reaches it through a plain register port with address, write data, write strobe, read strobe and combinational read data. Writes to the control, time and date registers are refused until a two-byte unlock sequence has been entered on the key register. Once unlocked, software raises an initialisation request. The calendar counter is held, and new time and date values can be loaded into it, only after the block acknowledges that request a fixed number of kernel-clock ticks later.

On the read side the block keeps shadow copies of the sub-second, time and date counter values, refreshed on every second kernel-clock tick. A sync flag records each refresh. Reading the sub-second or time shadow freezes all shadows until the date shadow is read, so a multi-word read returns one coherent instant. The kernel clock is modelled as a clock-enable pulse `kce` in the bus clock domain.

Top module: `rtc_regfront`

## Requirements
- R1: Writing 0xCA and then 0x53 to the key register (address 0) as two consecutive writes unlocks the block; STAT (address 2) bit 2 then reads 1.
- R2: Any write to the key register while unlocked locks the block again (STAT bit 2 reads 0).
- R3: After a correct first key, a wrong byte on the key register or a write to any other address returns the block to locked, and a following 0x53 does not unlock it.
- R4: While locked, writes to CTRL (address 1), TIME (address 4) and DATE (address 5) have no effect: CTRL bit 0 keeps its value and no load pulse reaches the counter.
- R5: After CTRL bit 0 (init request) is written to 1, the init-active flag (STAT bit 1, and the `cal_hold` output) rises on the second kernel tick after the write and not before.
- R6: Writing CTRL bit 0 to 0 drops init-active on the following clock.
- R7: A write to TIME or DATE while unlocked and init-active produces a one-cycle `cal_wr_time` or `cal_wr_date` pulse with the written data in the cycle after the write; the same write without init-active produces no pulse.
- R8: With the shadows unfrozen, the shadows take the counter values on every second kernel tick, and each such refresh sets the sync flag (STAT bit 0).
- R9: Writing STAT with bit 0 equal to 0 clears the sync flag; this needs no unlock.
- R10: Reading TIME (address 4) freezes the time and date shadows until DATE is read, so a later DATE read returns the value captured at the TIME read.
- R11: Reading SUBSEC (address 3) freezes the shadows the same way; reading DATE alone does not freeze them.
- R12: After reset the block is locked, init request and init-active are 0, the sync flag is 0 and no load pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kce | input | 1 | Kernel-clock tick enable |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data (combinational from addr) |
| cal_subsec | input | 16 | Live sub-second value from counter |
| cal_time | input | 24 | Live time value from counter |
| cal_date | input | 24 | Live date value from counter |
| cal_hold | output | 1 | Counter hold, equal to init-active |
| cal_wr_time | output | 1 | Load pulse for the time value |
| cal_wr_date | output | 1 | Load pulse for the date value |
| cal_wr_data | output | 32 | Data for the load pulses |

## Verification
The assertions take for granted that `wr_en` and `rd_en` never rise in the same cycle and that `addr` is stable while a strobe is high, since the freeze and key logic decode one access per cycle. They also assume the counter inputs only change between bus accesses. The bench drives every access from a task that raises exactly one strobe for one clock and changes counter values only between accesses. It stops `kce` whenever a check must not race a refresh.

// File: rtl/rtc_regfront_pkg.sv
package rtc_regfront_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_KEY    = 3'd0,
    RA_CTRL   = 3'd1,
    RA_STAT   = 3'd2,
    RA_SUBSEC = 3'd3,
    RA_TIME   = 3'd4,
    RA_DATE   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_st_e;

  // Next key state for one bus cycle.
  function automatic key_st_e key_next(key_st_e s, logic key_wr, logic other_wr,
                                       logic [7:0] d, logic [7:0] k1, logic [7:0] k2);
    key_st_e n;
    n = s;
    case (s)
      KS_LOCKED: if (key_wr && d == k1) n = KS_HALF;
      KS_HALF: begin
        if (key_wr && d == k2) n = KS_OPEN;
        else if (key_wr || other_wr) n = KS_LOCKED;
      end
      KS_OPEN: if (key_wr) n = KS_LOCKED;
      default: n = KS_LOCKED;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_key_fsm.sv
module rtc_key_fsm
  import rtc_regfront_pkg::*;
#(
  parameter logic [7:0] KEY1 = 8'hCA,
  parameter logic [7:0] KEY2 = 8'h53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic       other_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);

  key_st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KS_LOCKED;
    else        st <= key_next(st, key_wr, other_wr, key_byte, KEY1, KEY2);
  end

  assign unlocked = (st == KS_OPEN);

  // R1: opening happens only on the second key after the first
  a_r1_open_needs_key2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_byte == KEY2 && st == KS_HALF));

  // R2: any key write while open locks
  a_r2_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && unlocked) |=> !unlocked);

  // R3: any other access in the half state goes back to locked
  a_r3_half_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_HALF && other_wr) |=> st == KS_LOCKED);

endmodule

// File: rtl/rtc_init_hs.sv
module rtc_init_hs #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kce,
  input  logic req_we,
  input  logic req_val,
  output logic req,
  output logic active
);

  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else if (req_we) req <= req_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!req) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active && kce) begin
      if (cnt == CW'(DLY - 1)) active <= 1'b1;
      else                     cnt    <= cnt + 1'b1;
    end
  end

  // R5: acknowledge only rises while the request is held
  a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(req) && req);

  // R6: a withdrawn request drops the acknowledge next clock
  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !active);

endmodule

// File: rtl/rtc_shadow_sync.sv
module rtc_shadow_sync #(
  parameter int SS_W = 16,
  parameter int TM_W = 24,
  parameter int DT_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kce,
  input  logic [SS_W-1:0] cal_subsec,
  input  logic [TM_W-1:0] cal_time,
  input  logic [DT_W-1:0] cal_date,
  input  logic            rd_lo,
  input  logic            rd_date,
  input  logic            sync_clr,
  output logic [SS_W-1:0] sh_subsec,
  output logic [TM_W-1:0] sh_time,
  output logic [DT_W-1:0] sh_date,
  output logic            sync,
  output logic            frozen,
  output logic            refresh
);

  logic phase;

  // Refresh on every second kernel tick, never while frozen or being frozen.
  assign refresh = kce && phase && !frozen && !rd_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else if (kce) phase <= ~phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_subsec <= '0;
      sh_time   <= '0;
      sh_date   <= '0;
    end else if (refresh) begin
      sh_subsec <= cal_subsec;
      sh_time   <= cal_time;
      sh_date   <= cal_date;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frozen <= 1'b0;
    else if (rd_date) frozen <= 1'b0;
    else if (rd_lo) frozen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 1'b0;
    else if (refresh) sync <= 1'b1;
    else if (sync_clr) sync <= 1'b0;
  end

  // R8: the flag only rises on a refresh
  a_r8_sync_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(refresh));

  // R10: frozen shadows hold their value
  a_r10_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(sh_date) && $stable(sh_time));

  // R11: a low-order read freezes at once
  a_r11_lo_read_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_date) |=> frozen && $stable(sh_time));

endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
  import rtc_regfront_pkg::*;
#(
  parameter int         DW       = 32,
  parameter int         SS_W     = 16,
  parameter int         TM_W     = 24,
  parameter int         DT_W     = 24,
  parameter int         INIT_DLY = 2,
  parameter logic [7:0] KEY1     = 8'hCA,
  parameter logic [7:0] KEY2     = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kce,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic [SS_W-1:0]   cal_subsec,
  input  logic [TM_W-1:0]   cal_time,
  input  logic [DT_W-1:0]   cal_date,
  output logic              cal_hold,
  output logic              cal_wr_time,
  output logic              cal_wr_date,
  output logic [DW-1:0]     cal_wr_data
);

  localparam int PAD_SS = DW - SS_W;
  localparam int PAD_TM = DW - TM_W;
  localparam int PAD_DT = DW - DT_W;

  logic unlocked, init_req, init_active, sync, frozen, refresh;
  logic key_wr, other_wr, ctrl_we, stat_we, rd_lo, rd_date;
  logic time_load, date_load;
  logic [SS_W-1:0] sh_subsec;
  logic [TM_W-1:0] sh_time;
  logic [DT_W-1:0] sh_date;

  // Named bus events
  assign key_wr    = wr_en && addr == RA_KEY;
  assign other_wr  = wr_en && addr != RA_KEY;
  assign ctrl_we   = wr_en && addr == RA_CTRL && unlocked;
  assign stat_we   = wr_en && addr == RA_STAT;
  assign time_load = wr_en && addr == RA_TIME && unlocked && init_active;
  assign date_load = wr_en && addr == RA_DATE && unlocked && init_active;
  assign rd_lo     = rd_en && (addr == RA_SUBSEC || addr == RA_TIME);
  assign rd_date   = rd_en && addr == RA_DATE;

  rtc_key_fsm #(.KEY1(KEY1), .KEY2(KEY2)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .other_wr(other_wr),
    .key_byte(wr_data[7:0]), .unlocked(unlocked)
  );

  rtc_init_hs #(.DLY(INIT_DLY)) u_init (
    .clk(clk), .rst_n(rst_n), .kce(kce), .req_we(ctrl_we),
    .req_val(wr_data[0]), .req(init_req), .active(init_active)
  );

  rtc_shadow_sync #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .kce(kce),
    .cal_subsec(cal_subsec), .cal_time(cal_time), .cal_date(cal_date),
    .rd_lo(rd_lo), .rd_date(rd_date), .sync_clr(stat_we && !wr_data[0]),
    .sh_subsec(sh_subsec), .sh_time(sh_time), .sh_date(sh_date),
    .sync(sync), .frozen(frozen), .refresh(refresh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_wr_time <= 1'b0;
      cal_wr_date <= 1'b0;
      cal_wr_data <= '0;
    end else begin
      cal_wr_time <= time_load;
      cal_wr_date <= date_load;
      if (time_load || date_load) cal_wr_data <= wr_data;
    end
  end

  assign cal_hold = init_active;

  always_comb begin
    rd_data = '0;
    case (addr)
      RA_CTRL:   rd_data[0] = init_req;
      RA_STAT:   rd_data[2:0] = {unlocked, init_active, sync};
      RA_SUBSEC: rd_data = {{PAD_SS{1'b0}}, sh_subsec};
      RA_TIME:   rd_data = {{PAD_TM{1'b0}}, sh_time};
      RA_DATE:   rd_data = {{PAD_DT{1'b0}}, sh_date};
      default:   rd_data = '0;
    endcase
  end

  // R4 and R7: a load pulse needs the unlock and the acknowledge one cycle before
  a_r7_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_wr_time || cal_wr_date) |-> $past(unlocked && init_active));

  // R4: a locked CTRL write leaves the init request unchanged
  a_r4_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CTRL && !unlocked) |=> $stable(init_req));

  // R7: load pulses last one cycle per write
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr_time && !$past(wr_en) |-> 1'b0);

endmodule

// File: tb/tb_rtc_regfront.sv
module tb_rtc_regfront;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kce = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [15:0] cal_subsec = '0;
  logic [23:0] cal_time = '0;
  logic [23:0] cal_date = '0;
  logic        cal_hold, cal_wr_time, cal_wr_date;
  logic [31:0] cal_wr_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  rtc_regfront dut (
    .clk(clk), .rst_n(rst_n), .kce(kce), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .cal_subsec(cal_subsec), .cal_time(cal_time), .cal_date(cal_date),
    .cal_hold(cal_hold), .cal_wr_time(cal_wr_time), .cal_wr_date(cal_wr_date),
    .cal_wr_data(cal_wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access per clock: drive after a falling edge, return after the next one.
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(3'd0, 32'hCA);
    bus_wr(3'd0, 32'h53);
  endtask

  task automatic t_reset();
    bus_rd(3'd2, rv);  check("R12 stat", rv, 32'h0);
    bus_rd(3'd1, rv);  check("R12 ctrl", rv, 32'h0);
    check("R12 hold", {31'b0, cal_hold}, 32'h0);
    check("R12 load", {30'b0, cal_wr_time, cal_wr_date}, 32'h0);
  endtask

  task automatic t_keys();
    unlock();
    bus_rd(3'd2, rv); check("R1 unlocked", {31'b0, rv[2]}, 32'h1);
    bus_wr(3'd0, 32'hFF);
    bus_rd(3'd2, rv); check("R2 relocked", {31'b0, rv[2]}, 32'h0);
    unlock();
    bus_wr(3'd0, 32'hCA);
    bus_rd(3'd2, rv); check("R2 key write relocks", {31'b0, rv[2]}, 32'h0);
    bus_wr(3'd0, 32'hCA); bus_wr(3'd0, 32'h11); bus_wr(3'd0, 32'h53);
    bus_rd(3'd2, rv); check("R3 wrong key", {31'b0, rv[2]}, 32'h0);
    bus_wr(3'd0, 32'hCA); bus_wr(3'd2, 32'h1); bus_wr(3'd0, 32'h53);
    bus_rd(3'd2, rv); check("R3 other write", {31'b0, rv[2]}, 32'h0);
  endtask

  task automatic t_locked_writes();
    bus_wr(3'd1, 32'h1);
    bus_rd(3'd1, rv); check("R4 ctrl ignored", rv, 32'h0);
    kce = 1'b1; idle(4);
    check("R4 no hold", {31'b0, cal_hold}, 32'h0);
    kce = 1'b0;
  endtask

  task automatic t_init();
    unlock();
    kce = 1'b1;
    bus_wr(3'd1, 32'h1);
    check("R5 not after 0 ticks", {31'b0, cal_hold}, 32'h0);
    idle(1);
    check("R5 not after 1 tick", {31'b0, cal_hold}, 32'h0);
    idle(1);
    check("R5 active after 2 ticks", {31'b0, cal_hold}, 32'h1);
    bus_rd(3'd2, rv); check("R5 stat bit", {31'b0, rv[1]}, 32'h1);
    bus_wr(3'd4, 32'h00123456);
    check("R7 time pulse", {31'b0, cal_wr_time}, 32'h1);
    check("R7 time data", cal_wr_data, 32'h00123456);
    idle(1);
    check("R7 pulse one cycle", {31'b0, cal_wr_time}, 32'h0);
    bus_wr(3'd5, 32'h00250607);
    check("R7 date pulse", {31'b0, cal_wr_date}, 32'h1);
    check("R7 date data", cal_wr_data, 32'h00250607);
    bus_wr(3'd0, 32'hFF);
    bus_wr(3'd4, 32'h00111111);
    check("R4 locked time write", {31'b0, cal_wr_time}, 32'h0);
    unlock();
    bus_wr(3'd1, 32'h0);
    idle(1);
    check("R6 drop", {31'b0, cal_hold}, 32'h0);
    bus_wr(3'd4, 32'h00222222);
    check("R7 no pulse without init", {31'b0, cal_wr_time}, 32'h0);
    bus_wr(3'd0, 32'hFF);
    kce = 1'b0;
  endtask

  task automatic t_sync();
    cal_subsec = 16'h00AA; cal_time = 24'h101010; cal_date = 24'h240101;
    kce = 1'b1; idle(3); kce = 1'b0;
    bus_rd(3'd2, rv); check("R8 sync set", {31'b0, rv[0]}, 32'h1);
    bus_rd(3'd4, rv); check("R8 time shadow", rv, 32'h00101010);
    bus_rd(3'd5, rv); check("R8 date shadow", rv, 32'h00240101);
    bus_wr(3'd2, 32'h0);
    bus_rd(3'd2, rv); check("R9 sync cleared", {31'b0, rv[0]}, 32'h0);
    kce = 1'b1; idle(3); kce = 1'b0;
    bus_rd(3'd2, rv); check("R8 sync again", {31'b0, rv[0]}, 32'h1);
  endtask

  task automatic t_lock();
    kce = 1'b1;
    cal_subsec = 16'h0001; cal_time = 24'h111111; cal_date = 24'h111111; idle(3);
    bus_rd(3'd4, rv); check("R10 first time", rv, 32'h00111111);
    cal_subsec = 16'h0002; cal_time = 24'h222222; cal_date = 24'h222222; idle(5);
    bus_rd(3'd4, rv); check("R10 time held", rv, 32'h00111111);
    bus_rd(3'd5, rv); check("R10 date coherent", rv, 32'h00111111);
    idle(3);
    bus_rd(3'd4, rv); check("R10 released", rv, 32'h00222222);
    bus_rd(3'd5, rv);
    cal_subsec = 16'h0003; cal_time = 24'h333333; cal_date = 24'h333333; idle(3);
    bus_rd(3'd3, rv); check("R11 subsec", rv, 32'h00000003);
    cal_subsec = 16'h0004; cal_time = 24'h444444; cal_date = 24'h444444; idle(5);
    bus_rd(3'd4, rv); check("R11 time held", rv, 32'h00333333);
    bus_rd(3'd5, rv); check("R11 date held", rv, 32'h00333333);
    idle(3);
    bus_rd(3'd5, rv); check("R11 date refreshed", rv, 32'h00444444);
    cal_time = 24'h555555; idle(3);
    bus_rd(3'd4, rv); check("R11 date read no freeze", rv, 32'h00555555);
    bus_rd(3'd5, rv);
    kce = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_keys();
    t_locked_writes();
    t_init();
    t_sync();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule